// File: doc/BRIEF.md
# Coded Reference Divider with Test Port Routing

This block turns a reference clock into the phase-comparison strobe of a frequency synthesiser. A 5-bit ratio code picks one of 29 division ratios. They come in four families: powers of two from 2 to 256, and 5, 6 or 7 times a power of two up to 448. Codes outside the table are rejected. The divided output is a strobe one reference cycle wide that repeats once per selected ratio. A new ratio is only adopted at a terminal count, so a period already under way always finishes at its old length.

A 3-bit test code steers the loop for bring-up. Its two low bits force the charge pump to sink, to source, or to switch off, and while a test is active they override the reported lock flag. The high bit hands the general-purpose port over to an internal clock: either the half-rate feedback divider signal or the comparison strobe. When the high bit is clear, a register bit drives the port or leaves it floating.

Top module: `refdiv_testport`

## Requirements
- R1: After reset the strobe `fcomp` is low and the divider runs at ratio 2 until a legal code is adopted.
- R2: With code bits [4:3] = 00 and k = code[2:0], the strobe period is 2^(k+1) reference cycles (2 to 256).
- R3: With code bits [4:3] = 01, 10 or 11 and k = code[2:0] from 0 to 6, the period is B·2^k cycles, where B is 5, 6 or 7 for those three values.
- R4: Codes 01111, 10111 and 11111 are illegal and leave the current period unchanged.
- R5: A new code only takes effect at the next terminal count: the period in progress keeps its old length, and the next period uses the new ratio.
- R6: `fcomp` is high for exactly one reference cycle per period.
- R7: Test bits [1:0] set the pump controls: 01 asserts `pump_sink`, 10 asserts `pump_source`, 11 asserts `pump_off`, and 00 asserts none of them. This holds for either value of bit 2.
- R8: `lock_flag` follows `lock_raw` when test bits [1:0] = 00. It reads 0 when they are 01 or 10, and 1 when they are 11.
- R9: With test bit 2 = 0, `port_oe` equals `port_bit` and `port_val` is 1.
- R10: With test bit 2 = 1, `port_oe` is 1. `port_val` carries `fpd_half` when test bits [1:0] = 00 and `fcomp` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio_code | input | 5 | Division ratio code |
| test_code | input | 3 | Test mode code |
| port_bit | input | 1 | Port register bit used in normal mode |
| fpd_half | input | 1 | Half-rate feedback divider signal |
| lock_raw | input | 1 | Raw lock detector output |
| fcomp | output | 1 | Comparison strobe, one cycle per period |
| port_val | output | 1 | Value driven onto the port |
| port_oe | output | 1 | Port drive enable; 0 leaves the port floating |
| lock_flag | output | 1 | Reported lock flag |
| pump_sink | output | 1 | Force the charge pump to sink |
| pump_source | output | 1 | Force the charge pump to source |
| pump_off | output | 1 | Disable the charge pump |

## Verification
The bench measures strobe periods across every family, including the extremes 2 and 448. A decoder that mixes up the family base or shifts by the wrong amount would show a wrong period. It applies each illegal code after a known legal ratio. A design that decoded those codes would jump to a new period instead of keeping the old one. A code change is made deep inside a 448-cycle period. A design that reloads immediately would cut that period short. The port and lock overrides are checked under every test code while the strobe is both high and low, so a swapped clock source or a lock flag that is not overridden shows up as a value mismatch.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
    localparam int CODE_W      = 5;
    localparam int TEST_W      = 3;
    localparam int RATIO_W     = 9;
    localparam int RESET_RATIO = 2;

    typedef logic [RATIO_W-1:0] ratio_t;

    typedef struct packed {
        ratio_t cnt;
        ratio_t active;
        logic   strobe;
    } div_state_t;
endpackage

// File: rtl/refdiv_ratio_dec.sv
module refdiv_ratio_dec
    import refdiv_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output ratio_t            ratio,
    output logic              legal
);
    logic [1:0] family;
    logic [2:0] shift;
    ratio_t     base;

    always_comb begin
        family = code[4:3];
        shift  = code[2:0];
        if (family == 2'b00) begin
            base  = ratio_t'(2);
            legal = 1'b1;
        end else begin
            base  = ratio_t'({1'b0, family} + 3'd4);
            legal = (shift != 3'd7);
        end
        ratio = legal ? (base << shift) : ratio_t'(RESET_RATIO);
    end

    always_comb begin
        a_r4_illegal_flag: assert (!(code[4:3] != 2'b00 && code[2:0] == 3'd7) || !legal);
    end
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter
    import refdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  ratio_t new_ratio,
    input  logic   new_legal,
    output logic   strobe
);
    div_state_t st_q, st_d;
    ratio_t     next_ratio;
    logic       terminal;

    always_comb begin
        st_d       = st_q;
        terminal   = (st_q.cnt == '0);
        next_ratio = new_legal ? new_ratio : st_q.active;
        if (terminal) begin
            st_d.active = next_ratio;
            st_d.cnt    = next_ratio - ratio_t'(1);
            st_d.strobe = 1'b1;
        end else begin
            st_d.cnt    = st_q.cnt - ratio_t'(1);
            st_d.strobe = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt    <= ratio_t'(RESET_RATIO - 1);
            st_q.active <= ratio_t'(RESET_RATIO);
            st_q.strobe <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe = st_q.strobe;

    a_r5_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < st_q.active);
    a_r5_ratio_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0) |=> $stable(st_q.active));
    a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.strobe |=> !st_q.strobe);
    a_r4_ratio_min: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active >= ratio_t'(2));
endmodule

// File: rtl/refdiv_test_mux.sv
module refdiv_test_mux
    import refdiv_pkg::*;
(
    input  logic [TEST_W-1:0] test_code,
    input  logic              port_bit,
    input  logic              fpd_half,
    input  logic              strobe,
    input  logic              lock_raw,
    output logic              port_val,
    output logic              port_oe,
    output logic              lock_flag,
    output logic              pump_sink,
    output logic              pump_source,
    output logic              pump_off
);
    logic [1:0] pump_sel;

    always_comb begin
        pump_sel    = test_code[1:0];
        pump_sink   = (pump_sel == 2'b01);
        pump_source = (pump_sel == 2'b10);
        pump_off    = (pump_sel == 2'b11);
        unique case (pump_sel)
            2'b00:   lock_flag = lock_raw;
            2'b11:   lock_flag = 1'b1;
            default: lock_flag = 1'b0;
        endcase
        if (test_code[2]) begin
            port_oe  = 1'b1;
            port_val = (pump_sel == 2'b00) ? fpd_half : strobe;
        end else begin
            port_oe  = port_bit;
            port_val = 1'b1;
        end
    end

    always_comb begin
        a_r7_pump_exclusive: assert ($onehot0({pump_sink, pump_source, pump_off}));
        a_r8_forced_lock: assert (!(pump_sink || pump_source) || !lock_flag);
        a_r10_port_owned: assert (!test_code[2] || port_oe);
    end
endmodule

// File: rtl/refdiv_testport.sv
module refdiv_testport
    import refdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] ratio_code,
    input  logic [TEST_W-1:0] test_code,
    input  logic              port_bit,
    input  logic              fpd_half,
    input  logic              lock_raw,
    output logic              fcomp,
    output logic              port_val,
    output logic              port_oe,
    output logic              lock_flag,
    output logic              pump_sink,
    output logic              pump_source,
    output logic              pump_off
);
    ratio_t dec_ratio;
    logic   dec_legal;
    logic   strobe;

    refdiv_ratio_dec u_dec (
        .code  (ratio_code),
        .ratio (dec_ratio),
        .legal (dec_legal)
    );

    refdiv_counter u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .new_ratio (dec_ratio),
        .new_legal (dec_legal),
        .strobe    (strobe)
    );

    refdiv_test_mux u_mux (
        .test_code   (test_code),
        .port_bit    (port_bit),
        .fpd_half    (fpd_half),
        .strobe      (strobe),
        .lock_raw    (lock_raw),
        .port_val    (port_val),
        .port_oe     (port_oe),
        .lock_flag   (lock_flag),
        .pump_sink   (pump_sink),
        .pump_source (pump_source),
        .pump_off    (pump_off)
    );

    assign fcomp = strobe;

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !fcomp);
endmodule

// File: tb/sim_refdiv_testport.sv
module sim_refdiv_testport;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] ratio_code = 5'd0;
    logic [2:0] test_code = 3'd0;
    logic       port_bit = 1'b0;
    logic       fpd_half = 1'b0;
    logic       lock_raw = 1'b0;
    logic       fcomp, port_val, port_oe, lock_flag;
    logic       pump_sink, pump_source, pump_off;

    int checks = 0;
    int fails  = 0;
    int cycle  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cycle <= cycle + 1;

    refdiv_testport u0 (
        .clk(clk), .rst_n(rst_n), .ratio_code(ratio_code), .test_code(test_code),
        .port_bit(port_bit), .fpd_half(fpd_half), .lock_raw(lock_raw),
        .fcomp(fcomp), .port_val(port_val), .port_oe(port_oe), .lock_flag(lock_flag),
        .pump_sink(pump_sink), .pump_source(pump_source), .pump_off(pump_off)
    );

    function automatic int exp_ratio(input logic [4:0] c);
        int fam = int'(c[4:3]);
        int k   = int'(c[2:0]);
        if (fam == 0) return 2 << k;
        if (k == 7) return -1;
        return (fam + 4) << k;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic next_pulse(output int at);
        do @(negedge clk); while (fcomp !== 1'b1);
        at = cycle;
    endtask

    // skip the period in progress, then measure one full new period
    task automatic settled_period(output int per);
        int a, b;
        next_pulse(a);
        next_pulse(a);
        next_pulse(b);
        per = b - a;
    endtask

    task automatic check_mux(input string tag);
        int exp_lock, exp_oe, exp_val;
        case (test_code[1:0])
            2'b00: exp_lock = int'(lock_raw);
            2'b11: exp_lock = 1;
            default: exp_lock = 0;
        endcase
        check({tag, " R7 sink"},   int'(pump_sink),   int'(test_code[1:0] == 2'b01));
        check({tag, " R7 source"}, int'(pump_source), int'(test_code[1:0] == 2'b10));
        check({tag, " R7 off"},    int'(pump_off),    int'(test_code[1:0] == 2'b11));
        check({tag, " R8 lock"},   int'(lock_flag),   exp_lock);
        if (test_code[2]) begin
            exp_oe  = 1;
            exp_val = (test_code[1:0] == 2'b00) ? int'(fpd_half) : int'(fcomp);
            check({tag, " R10 oe"},  int'(port_oe),  exp_oe);
            check({tag, " R10 val"}, int'(port_val), exp_val);
        end else begin
            check({tag, " R9 oe"},  int'(port_oe),  int'(port_bit));
            check({tag, " R9 val"}, int'(port_val), 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int per, a, b;
        logic [4:0] c;
        void'($urandom(32'd4242));

        repeat (3) @(negedge clk);
        check("R1 fcomp low in reset", int'(fcomp), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 fcomp low after reset", int'(fcomp), 0);
        next_pulse(a);
        next_pulse(b);
        check("R1 reset ratio", b - a, 2);
        @(negedge clk);
        check("R6 single cycle width", int'(fcomp), 0);

        // R2 every power-of-two code
        for (int k = 0; k < 8; k++) begin
            ratio_code = {2'b00, 3'(k)};
            settled_period(per);
            check("R2 power of two", per, exp_ratio(ratio_code));
        end

        // R3 extremes and R4 illegal codes
        for (int f = 1; f < 4; f++) begin
            ratio_code = {2'(f), 3'd0};
            settled_period(per);
            check("R3 family low", per, exp_ratio(ratio_code));
            ratio_code = {2'(f), 3'd6};
            settled_period(per);
            check("R3 family high", per, exp_ratio(ratio_code));
            ratio_code = {2'(f), 3'd7};
            settled_period(per);
            check("R4 illegal holds", per, (f + 4) << 6);
        end

        // R5 change mid-period at ratio 448
        ratio_code = 5'b11110;
        settled_period(per);
        next_pulse(a);
        repeat (100) @(negedge clk);
        ratio_code = 5'b00000;
        next_pulse(b);
        check("R5 period in progress kept", b - a, 448);
        next_pulse(a);
        check("R5 new ratio next period", a - b, 2);

        // R6 pulse width at a longer ratio
        ratio_code = 5'b01001;
        settled_period(per);
        @(negedge clk);
        check("R6 single cycle width", int'(fcomp), 0);

        // random legal ratios
        for (int i = 0; i < 20; i++) begin
            do c = 5'($urandom); while (exp_ratio(c) < 0 || exp_ratio(c) > 200);
            ratio_code = c;
            settled_period(per);
            check("R3 random ratio", per, exp_ratio(c));
        end

        // test mux: directed over all codes, strobe high and low
        ratio_code = 5'b00001;
        for (int t = 0; t < 8; t++) begin
            test_code = 3'(t);
            for (int s = 0; s < 4; s++) begin
                port_bit = s[0];
                fpd_half = s[1];
                lock_raw = ~s[0];
                next_pulse(a);
                check_mux("pulse");
                @(negedge clk);
                check_mux("idle");
            end
        end

        // random mux stimulus
        for (int i = 0; i < 60; i++) begin
            test_code = 3'($urandom);
            port_bit  = 1'($urandom);
            fpd_half  = 1'($urandom);
            lock_raw  = 1'($urandom);
            @(negedge clk);
            check_mux("rand");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule